// File: doc/BRIEF.md
# Memory Access Alignment Fault Checker

This block sits between the load/store/fetch stage of a processor core and its memory port. Every access request is checked for natural alignment in the cycle it is presented. An aligned request is passed to memory in that same cycle. A misaligned request is held back from memory and turned into an exception for the trap unit.

The block also watches the error flag that the memory returns on a response. It keeps the kind and address of the most recently issued access. When that access comes back with an error, the block raises the matching access-fault exception. Each exception is reported as a registered one-cycle pulse, together with a 4-bit cause code and the faulting address. A flush input discards any pending report.

Fetch alignment follows the compressed-instruction flag. With the flag set, fetches need 2-byte alignment. With it clear, fetches need 4-byte alignment.

Top module: `mem_align_chk`

## Requirements
- R1: A fetch (kind 0) is misaligned when `comp_en`=1 and `req_addr[0]`=1. It is also misaligned when `comp_en`=0 and `req_addr[1:0]`≠0. `req_len` plays no part in the fetch check.
- R2: For a load (kind 1) or a store (kind 2), `req_len` gives the byte count. A 2-byte access is misaligned when `req_addr[0]`=1, and a 4-byte access when `req_addr[1:0]`≠0. Any other length is never misaligned.
- R3: `mem_req_valid` follows a valid aligned fetch, load or store combinationally in the same cycle. It stays low for a misaligned request.
- R4: A valid misaligned request sets `trap_valid` in the next cycle. `trap_cause` is then 0 for a fetch, 4 for a load and 6 for a store, and `trap_val` is the request address.
- R5: A cycle with `rsp_valid`=1 and `rsp_err`=1 sets `trap_valid` in the next cycle. `trap_cause` is then 1, 5 or 7 for a fetch, load or store. The kind and the `trap_val` come from the access most recently passed to memory before that cycle.
- R6: When a misaligned request and an error response fall in the same cycle, only the alignment fault is reported.
- R7: `trap_valid` is high only in the cycle after a qualifying event. A response with `rsp_err`=0, an aligned request, and an idle cycle all leave it low in the next cycle.
- R8: In the cycle after `flush` is high, `trap_valid` is low. Any event in the flush cycle is discarded.
- R9: Kind 3 is reserved. A request of kind 3 never drives `mem_req_valid` and never raises a trap.
- R10: While `rst_n` is low, and just after it, `trap_valid`, `trap_cause` and `trap_val` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discards the trap report of this cycle |
| req_valid | input | 1 | An access request is presented |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| req_len | input | 3 | Byte length of a load or store (1, 2 or 4) |
| req_addr | input | ADDR_W | Access address |
| comp_en | input | 1 | Compressed instructions supported (2-byte fetch granule) |
| rsp_valid | input | 1 | Memory response for the last issued access |
| rsp_err | input | 1 | The response carries an error |
| mem_req_valid | output | 1 | Request forwarded to memory |
| trap_valid | output | 1 | One-cycle exception report |
| trap_cause | output | 4 | Exception cause code |
| trap_val | output | ADDR_W | Faulting address |

## Verification
The bench builds the block with its defaults: ADDR_W=32 and ALLOW_COMP=1. This means the runtime `comp_en` flag really does switch the fetch granule, so both fetch rules in R1 are reached by toggling one input. Random addresses cover all four values of the low two bits against every kind and length. Error responses, flushes and misaligned requests collide in random cycles, which reaches the priority and discard cases. A directed prologue pins down each cause code and the reserved kind first.

// File: rtl/align_pkg.sv
package align_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   localparam int CAUSE_W = 4;

   function automatic logic [CAUSE_W-1:0] misalign_cause(acc_kind_e k);
      case (k)
         ACC_LOAD:  return 4'd4;
         ACC_STORE: return 4'd6;
         default:   return 4'd0;
      endcase
   endfunction

   function automatic logic [CAUSE_W-1:0] access_cause(acc_kind_e k);
      case (k)
         ACC_LOAD:  return 4'd5;
         ACC_STORE: return 4'd7;
         default:   return 4'd1;
      endcase
   endfunction
endpackage

// File: rtl/align_detect.sv
module align_detect
   import align_pkg::*;
#(
   parameter bit ALLOW_COMP = 1'b1
) (
   input  acc_kind_e  kind,
   input  logic [2:0] len,
   input  logic [1:0] addr_lo,
   input  logic       comp_en,
   output logic       misaligned
);
   logic [1:0] fetch_mask;
   logic [1:0] data_mask;

   generate
      if (ALLOW_COMP) begin : g_comp
         assign fetch_mask = comp_en ? 2'b01 : 2'b11;
      end else begin : g_nocomp
         logic unused_comp;
         assign unused_comp = comp_en;
         assign fetch_mask  = 2'b11;
      end
   endgenerate

   always_comb begin
      case (len)
         3'd2:    data_mask = 2'b01;
         3'd4:    data_mask = 2'b11;
         default: data_mask = 2'b00;
      endcase
   end

   always_comb begin
      case (kind)
         ACC_FETCH:          misaligned = |(addr_lo & fetch_mask);
         ACC_LOAD, ACC_STORE: misaligned = |(addr_lo & data_mask);
         default:            misaligned = 1'b0;
      endcase
   end
endmodule

// File: rtl/pend_track.sv
module pend_track
   import align_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  acc_kind_e         kind_in,
   input  logic [ADDR_W-1:0] addr_in,
   output acc_kind_e         kind_q,
   output logic [ADDR_W-1:0] addr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= ACC_FETCH;
         addr_q <= '0;
      end else if (capture) begin
         kind_q <= kind_in;
         addr_q <= addr_in;
      end
   end
endmodule

// File: rtl/fault_reg.sv
module fault_reg
   import align_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               mis_fire,
   input  logic [CAUSE_W-1:0] mis_cause,
   input  logic [ADDR_W-1:0]  mis_addr,
   input  logic               flt_fire,
   input  logic [CAUSE_W-1:0] flt_cause,
   input  logic [ADDR_W-1:0]  flt_addr,
   output logic               trap_valid,
   output logic [CAUSE_W-1:0] trap_cause,
   output logic [ADDR_W-1:0]  trap_val
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_valid <= 1'b0;
         trap_cause <= '0;
         trap_val   <= '0;
      end else begin
         trap_valid <= !flush && (mis_fire || flt_fire);
         if (!flush && mis_fire) begin
            trap_cause <= mis_cause;
            trap_val   <= mis_addr;
         end else if (!flush && flt_fire) begin
            trap_cause <= flt_cause;
            trap_val   <= flt_addr;
         end
      end
   end
endmodule

// File: rtl/mem_align_chk.sv
module mem_align_chk
   import align_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit ALLOW_COMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [2:0]        req_len,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              comp_en,
   input  logic              rsp_valid,
   input  logic              rsp_err,
   output logic              mem_req_valid,
   output logic              trap_valid,
   output logic [3:0]        trap_cause,
   output logic [ADDR_W-1:0] trap_val
);
   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("mem_align_chk: ADDR_W must be at least 2");
      end
   endgenerate

   acc_kind_e         kind;
   acc_kind_e         pend_kind;
   logic [ADDR_W-1:0] pend_addr;
   logic              misaligned;
   logic              known_kind;

   assign kind       = acc_kind_e'(req_kind);
   assign known_kind = (kind != ACC_RSVD);

   align_detect #(.ALLOW_COMP(ALLOW_COMP)) u_detect (
      .kind       (kind),
      .len        (req_len),
      .addr_lo    (req_addr[1:0]),
      .comp_en    (comp_en),
      .misaligned (misaligned)
   );

   assign mem_req_valid = req_valid && known_kind && !misaligned;

   pend_track #(.ADDR_W(ADDR_W)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (mem_req_valid),
      .kind_in (kind),
      .addr_in (req_addr),
      .kind_q  (pend_kind),
      .addr_q  (pend_addr)
   );

   fault_reg #(.ADDR_W(ADDR_W)) u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .mis_fire   (req_valid && known_kind && misaligned),
      .mis_cause  (misalign_cause(kind)),
      .mis_addr   (req_addr),
      .flt_fire   (rsp_valid && rsp_err),
      .flt_cause  (access_cause(pend_kind)),
      .flt_addr   (pend_addr),
      .trap_valid (trap_valid),
      .trap_cause (trap_cause),
      .trap_val   (trap_val)
   );
endmodule

// File: rtl/mem_align_chk_sva.sv
module mem_align_chk_sva #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              req_valid,
   input logic [1:0]        req_kind,
   input logic [2:0]        req_len,
   input logic [ADDR_W-1:0] req_addr,
   input logic              comp_en,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic              mem_req_valid,
   input logic              trap_valid,
   input logic [3:0]        trap_cause,
   input logic [ADDR_W-1:0] trap_val
);
   p_fetch4_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd0 && !comp_en && req_addr[1:0] == 2'd2) |-> !mem_req_valid);

   p_ld_mis_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd1 && req_len == 3'd4 && req_addr[1:0] != 2'd0 && !flush)
      |=> (trap_valid && trap_cause == 4'd4 && trap_val == $past(req_addr)));

   p_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> req_valid);

   p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_kind == 2'd3) |-> !mem_req_valid);

   p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !trap_valid);

   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !(rsp_valid && rsp_err)) |=> !trap_valid);
endmodule

bind mem_align_chk mem_align_chk_sva #(.ADDR_W(ADDR_W)) u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .flush         (flush),
   .req_valid     (req_valid),
   .req_kind      (req_kind),
   .req_len       (req_len),
   .req_addr      (req_addr),
   .comp_en       (comp_en),
   .rsp_valid     (rsp_valid),
   .rsp_err       (rsp_err),
   .mem_req_valid (mem_req_valid),
   .trap_valid    (trap_valid),
   .trap_cause    (trap_cause),
   .trap_val      (trap_val)
);

// File: tb/mem_align_chk_tb.sv
module mem_align_chk_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [2:0]  req_len = 3'd1;
   logic [31:0] req_addr = '0;
   logic        comp_en = 1'b1;
   logic        rsp_valid = 1'b0;
   logic        rsp_err = 1'b0;
   logic        mem_req_valid;
   logic        trap_valid;
   logic [3:0]  trap_cause;
   logic [31:0] trap_val;

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit cmp_en = 0;

   // reference model state
   bit          m_tv;
   int          m_cause;
   logic [31:0] m_val;
   int          m_pkind;
   logic [31:0] m_paddr;
   string       m_tag = "R10";

   always #2 clk = ~clk;

   mem_align_chk u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
      .req_kind(req_kind), .req_len(req_len), .req_addr(req_addr),
      .comp_en(comp_en), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .mem_req_valid(mem_req_valid), .trap_valid(trap_valid),
      .trap_cause(trap_cause), .trap_val(trap_val)
   );

   // R1, R2: alignment rule from the requirement text
   function automatic bit ref_mis(int k, int len, logic [31:0] a, bit c);
      if (k == 0) return c ? (a % 2 != 0) : (a % 4 != 0);
      if (k == 1 || k == 2) begin
         if (len == 2) return a % 2 != 0;
         if (len == 4) return a % 4 != 0;
      end
      return 0;
   endfunction

   function automatic bit ref_issue();
      return req_valid && req_kind != 3 &&
             !ref_mis(req_kind, req_len, req_addr, comp_en);
   endfunction

   always @(posedge clk) begin
      bit mis, err;
      if (!rst_n) begin
         m_tv = 0; m_cause = 0; m_val = '0; m_pkind = 0; m_paddr = '0; m_tag = "R10";
      end else begin
         mis = req_valid && req_kind != 3 && ref_mis(req_kind, req_len, req_addr, comp_en);
         err = rsp_valid && rsp_err;
         m_tv = 0;
         if (flush) m_tag = "R8";
         else if (mis) begin
            m_tv = 1;
            m_cause = (req_kind == 1) ? 4 : (req_kind == 2) ? 6 : 0;
            m_val = req_addr;
            m_tag = err ? "R6" : "R4";
         end else if (err) begin
            m_tv = 1;
            m_cause = (m_pkind == 1) ? 5 : (m_pkind == 2) ? 7 : 1;
            m_val = m_paddr;
            m_tag = "R5";
         end else m_tag = (req_valid && req_kind == 3) ? "R9" : "R7";
         if (ref_issue()) begin
            m_pkind = req_kind;
            m_paddr = req_addr;
         end
      end
   end

   // compare registered outputs every cycle, away from the edge
   always @(negedge clk) begin
      if (cmp_en) begin
         total++;
         if (trap_valid !== m_tv ||
             (m_tv && (trap_cause !== 4'(m_cause) || trap_val !== m_val))) begin
            bad++;
            $display("FAIL %s: trap v/c/val=%0b/%0d/%h expected %0b/%0d/%h",
                     m_tag, trap_valid, trap_cause, trap_val, m_tv, m_cause, m_val);
         end
      end
   end

   task automatic drive(bit v, int k, int len, logic [31:0] a, bit c,
                        bit rv, bit re, bit fl);
      bit exp;
      @(negedge clk);
      req_valid = v; req_kind = 2'(k); req_len = 3'(len); req_addr = a;
      comp_en = c; rsp_valid = rv; rsp_err = re; flush = fl;
      #1;
      exp = ref_issue();
      total++;
      if (mem_req_valid !== exp) begin
         bad++;
         $display("FAIL %s: mem_req_valid=%0b expected %0b (kind %0d len %0d addr %h)",
                  (k == 3) ? "R9" : "R3", mem_req_valid, exp, k, len, a);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset values
      total++;
      if (trap_valid !== 0 || trap_cause !== 0 || trap_val !== 0) begin
         bad++;
         $display("FAIL R10: reset v/c/val=%0b/%0d/%h expected 0/0/0",
                  trap_valid, trap_cause, trap_val);
      end
      rst_n = 1'b1;
      cmp_en = 1;
      // R1: fetch granule follows comp_en
      drive(1, 0, 4, 32'h1002, 1, 0, 0, 0);
      drive(1, 0, 4, 32'h1002, 0, 0, 0, 0);
      drive(1, 0, 4, 32'h1001, 1, 0, 0, 0);
      // R2: load/store lengths
      drive(1, 1, 2, 32'h2001, 1, 0, 0, 0);
      drive(1, 2, 4, 32'h3002, 1, 0, 0, 0);
      drive(1, 1, 1, 32'h2003, 1, 0, 0, 0);
      // R5: error on the byte load just issued
      drive(0, 0, 1, 32'h0, 1, 1, 1, 0);
      drive(1, 2, 4, 32'h4000, 1, 0, 0, 0);
      drive(0, 0, 1, 32'h0, 1, 1, 1, 0);
      // R7: good response, idle
      drive(0, 0, 1, 32'h0, 1, 1, 0, 0);
      // R6: misaligned load together with an error response
      drive(1, 1, 4, 32'h5001, 1, 1, 1, 0);
      // R8: flush drops a misaligned store
      drive(1, 2, 2, 32'h6001, 1, 0, 0, 1);
      // R9: reserved kind with a misaligned-looking address
      drive(1, 3, 4, 32'h7003, 0, 0, 0, 0);
      drive(0, 0, 1, 32'h0, 1, 0, 0, 0);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int lens[3] = '{1, 2, 4};
         drive($urandom_range(0, 3) != 0, $urandom_range(0, 3),
               lens[$urandom_range(0, 2)], $urandom(), $urandom_range(0, 1),
               $urandom_range(0, 2) == 0, $urandom_range(0, 1),
               $urandom_range(0, 9) == 0);
      end
      drive(0, 0, 1, 32'h0, 1, 0, 0, 0);
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule